// File: doc/BRIEF.md
# Write-Protect Boundary Register with Permanent Lock

This block keeps the write-protection state of a small serial memory: a boundary address, a flag that says whether a boundary is in force, and a lock bit that can be set once and never cleared. It receives already-decoded instruction strobes with an address-sized operand and the levels of the protect-enable and write-enable pins. It executes the protect instructions that read, arm, clear, write and lock the boundary. Each instruction takes effect only when its pin and ordering qualifications hold.

The memory write path asks the block through a combinational compare port whether a target address is protected. When a qualified modification is accepted, the block raises a one-cycle start pulse that tells the write engine to begin a busy period. A read of the boundary returns a one-cycle result word. Neither output stream has back-pressure: a consumer must take the pulse in the cycle it appears, and the block never stalls its command input.

The boundary, flag and lock model nonvolatile cells. They are cleared only by the power-on reset `por_n`. The functional reset `rst_n` clears only the volatile write-enable and arming state and the output pulses.

Top module: `prot_guard`

## Requirements
- R1: After power-on reset the boundary is 8'hFF, the flag is 1 and the lock is clear. No address reports protected, `allow_all` is 1, and `start_busy` and `rd_valid` are 0.
- R2: A qualified boundary write (op code 6) stores `cmd_operand` as the boundary and sets the flag to 0, so `allow_all` becomes 0. From then on `chk_protected` is 1 exactly for addresses at or above the boundary. `start_busy` pulses for one cycle in the cycle after the command.
- R3: A qualified boundary clear (op code 5) sets the boundary to all ones and the flag to 1. `allow_all` becomes 1, no address reports protected, and `start_busy` pulses once.
- R4: Arming (op code 4) succeeds only when write enable (op code 1) was executed earlier and both pins are high. Arming leaves the flag unchanged. Ops 5, 6 and 7 are qualified only when the command immediately before them was a successful arm. Any other command in between cancels the arming (op code 0 stands for all non-protect instructions).
- R5: Ops 5, 6 and 7 also need `pin_pre` and `pin_wr` both high in their own command cycle. Otherwise they change nothing and give no `start_busy`.
- R6: A boundary read (op code 3) with `pin_pre` high pulses `rd_valid` in the cycle after the command. `rd_data[8:1]` holds the boundary and `rd_data[0]` holds the flag. With `pin_pre` low no `rd_valid` appears.
- R7: A qualified lock (op code 7) sets the lock bit and pulses `start_busy`. After that, ops 5, 6 and 7 never change the boundary or flag and never pulse `start_busy`. The lock survives the functional reset.
- R8: The functional reset clears the write-enable and arming state but keeps the boundary, flag and lock.
- R9: Write disable (op code 2) clears write enable, so a later arm fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Functional reset, active low, synchronous |
| por_n | input | 1 | Power-on reset, active low, synchronous; also clears nonvolatile state |
| cmd_valid | input | 1 | One decoded instruction is present this cycle |
| cmd_op | input | 3 | Instruction code (0 other, 1 write enable, 2 write disable, 3 read, 4 arm, 5 clear, 6 write, 7 lock) |
| cmd_operand | input | 8 | Address operand of the instruction |
| pin_pre | input | 1 | Protect-enable pin level |
| pin_wr | input | 1 | Write-enable pin level |
| chk_addr | input | 8 | Address to test against the boundary |
| chk_protected | output | 1 | `chk_addr` lies in the protected area |
| allow_all | output | 1 | Flag is 1: whole-array write permitted |
| start_busy | output | 1 | One-cycle pulse: start a programming busy period |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a read result |
| rd_data | output | 9 | Boundary in [8:1], flag in [0] |

## Verification
A command is sampled on the rising edge where `cmd_valid` is high. The state it changes is visible on `chk_protected` and `allow_all` right after that edge. `start_busy` and `rd_valid` are registered at the same edge and stay high only until the next one. The bench drives each command on a falling edge, lets one rising edge pass, and checks all outputs on the following falling edge, which is inside the single pulse cycle. Cases that must have no effect are checked through the compare port and a later boundary read, before any further command can change the state.

// File: rtl/prot_pkg.sv
`timescale 1ns/1ps
package prot_pkg;
  typedef enum logic [2:0] {
    OP_OTHER = 3'd0,
    OP_WEN   = 3'd1,
    OP_WDS   = 3'd2,
    OP_READ  = 3'd3,
    OP_ARM   = 3'd4,
    OP_CLEAR = 3'd5,
    OP_WRITE = 3'd6,
    OP_LOCK  = 3'd7
  } prot_op_e;

  typedef struct packed {
    logic clear;
    logic write;
    logic lock;
  } prot_grant_t;
endpackage

// File: rtl/prot_qual.sv
`timescale 1ns/1ps
module prot_qual
  import prot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_n,
  input  logic        cmd_valid,
  input  prot_op_e    op,
  input  logic        pin_pre,
  input  logic        pin_wr,
  input  logic        lock_q,
  output prot_grant_t grant,
  output logic        rd_req
);
  logic wen_q;
  logic armed_q;
  logic modify_ok;
  logic arm_ok;

  // Modifications need the arm, both pins, and an unlocked register
  assign modify_ok = cmd_valid && armed_q && pin_pre && pin_wr && !lock_q;
  assign arm_ok    = wen_q && pin_pre && pin_wr;

  always_comb begin
    grant.clear = modify_ok && (op == OP_CLEAR);
    grant.write = modify_ok && (op == OP_WRITE);
    grant.lock  = modify_ok && (op == OP_LOCK);
  end

  assign rd_req = cmd_valid && (op == OP_READ) && pin_pre;

  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) begin
      wen_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (cmd_valid) begin
      // Every command consumes or replaces the arm
      armed_q <= (op == OP_ARM) && arm_ok;
      if (op == OP_WEN)      wen_q <= 1'b1;
      else if (op == OP_WDS) wen_q <= 1'b0;
    end
  end
endmodule

// File: rtl/prot_store.sv
`timescale 1ns/1ps
module prot_store
  import prot_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  prot_grant_t   grant,
  input  logic [AW-1:0] operand,
  output logic [AW-1:0] bound_q,
  output logic          flag_q,
  output logic          lock_q
);
  // Nonvolatile model: only power-on reset touches these cells
  always_ff @(posedge clk) begin
    if (!por_n) begin
      bound_q <= '1;
      flag_q  <= 1'b1;
      lock_q  <= 1'b0;
    end else begin
      if (grant.write) begin
        bound_q <= operand;
        flag_q  <= 1'b0;
      end else if (grant.clear) begin
        bound_q <= '1;
        flag_q  <= 1'b1;
      end
      if (grant.lock) lock_q <= 1'b1;
    end
  end
endmodule

// File: rtl/prot_cmp.sv
`timescale 1ns/1ps
module prot_cmp #(
  parameter int AW        = 8,
  parameter bit INCLUSIVE = 1'b1
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] bound,
  input  logic          flag,
  output logic          hit
);
  logic above;
  generate
    if (INCLUSIVE) begin : g_incl
      assign above = (addr >= bound);
    end else begin : g_excl
      assign above = (addr > bound);
    end
  endgenerate

  // Flag at 1 means no boundary is in force
  assign hit = !flag && above;
endmodule

// File: rtl/prot_guard.sv
`timescale 1ns/1ps
module prot_guard
  import prot_pkg::*;
#(
  parameter int AW = 8,
  localparam int RW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_operand,
  input  logic          pin_pre,
  input  logic          pin_wr,
  input  logic [AW-1:0] chk_addr,
  output logic          chk_protected,
  output logic          allow_all,
  output logic          start_busy,
  output logic          rd_valid,
  output logic [RW-1:0] rd_data
);
  prot_op_e    op;
  prot_grant_t grant;
  logic        rd_req;
  logic [AW-1:0] bound_q;
  logic        flag_q;
  logic        lock_q;

  assign op = prot_op_e'(cmd_op);

  prot_qual u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .cmd_valid (cmd_valid),
    .op        (op),
    .pin_pre   (pin_pre),
    .pin_wr    (pin_wr),
    .lock_q    (lock_q),
    .grant     (grant),
    .rd_req    (rd_req)
  );

  prot_store #(.AW(AW)) u_store (
    .clk     (clk),
    .por_n   (por_n),
    .grant   (grant),
    .operand (cmd_operand),
    .bound_q (bound_q),
    .flag_q  (flag_q),
    .lock_q  (lock_q)
  );

  prot_cmp #(.AW(AW), .INCLUSIVE(1'b1)) u_cmp (
    .addr  (chk_addr),
    .bound (bound_q),
    .flag  (flag_q),
    .hit   (chk_protected)
  );

  assign allow_all = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) begin
      start_busy <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      start_busy <= |grant;
      rd_valid   <= rd_req;
      if (rd_req) rd_data <= {bound_q, flag_q};
    end
  end
endmodule

// File: rtl/prot_guard_chk.sv
`timescale 1ns/1ps
module prot_guard_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic          pin_pre,
  input logic          pin_wr,
  input logic          start_busy,
  input logic          rd_valid,
  input logic          lock_q,
  input logic [AW-1:0] bound_q
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    $past(lock_q) |-> lock_q); // R7

  AST_BOUND_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    $past(lock_q) |-> $stable(bound_q)); // R7

  AST_NO_BUSY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $past(lock_q) |-> !start_busy); // R7

  AST_BUSY_PINS: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    start_busy |-> $past(cmd_valid && pin_pre && pin_wr && (cmd_op >= 3'd5))); // R5

  AST_READ_QUAL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    rd_valid |-> $past(cmd_valid && pin_pre && (cmd_op == 3'd3))); // R6

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(start_busy && rd_valid)); // R6
endmodule

bind prot_guard prot_guard_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_n      (por_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .pin_pre    (pin_pre),
  .pin_wr     (pin_wr),
  .start_busy (start_busy),
  .rd_valid   (rd_valid),
  .lock_q     (lock_q),
  .bound_q    (bound_q)
);

// File: tb/tb_prot_guard.sv
`timescale 1ns/1ps
module tb_prot_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_operand = 8'h00;
  logic       pin_pre = 1'b0;
  logic       pin_wr = 1'b0;
  logic [7:0] chk_addr = 8'h00;
  logic       chk_protected;
  logic       allow_all;
  logic       start_busy;
  logic       rd_valid;
  logic [8:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prot_guard dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_operand(cmd_operand), .pin_pre(pin_pre),
    .pin_wr(pin_wr), .chk_addr(chk_addr), .chk_protected(chk_protected),
    .allow_all(allow_all), .start_busy(start_busy), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  // {op, operand, pre, wr, probe, e_busy, e_rdv, e_rdata, e_prot, e_all}
  localparam int NV = 27;
  localparam logic [33:0] VEC [NV] = '{
    {3'd3, 8'h00, 2'b11, 8'h00, 2'b01, 9'h1FF, 2'b01},
    {3'd4, 8'h00, 2'b11, 8'h00, 2'b00, 9'h000, 2'b01},
    {3'd6, 8'h40, 2'b11, 8'h40, 2'b00, 9'h000, 2'b01},
    {3'd1, 8'h00, 2'b11, 8'h40, 2'b00, 9'h000, 2'b01},
    {3'd4, 8'h00, 2'b11, 8'h40, 2'b00, 9'h000, 2'b01},
    {3'd6, 8'h40, 2'b11, 8'h40, 2'b10, 9'h000, 2'b10},
    {3'd3, 8'h00, 2'b11, 8'h3F, 2'b01, 9'h080, 2'b00},
    {3'd4, 8'h00, 2'b11, 8'h40, 2'b00, 9'h000, 2'b10},
    {3'd0, 8'h00, 2'b11, 8'h40, 2'b00, 9'h000, 2'b10},
    {3'd6, 8'h10, 2'b11, 8'h20, 2'b00, 9'h000, 2'b00},
    {3'd4, 8'h00, 2'b11, 8'h40, 2'b00, 9'h000, 2'b10},
    {3'd5, 8'h00, 2'b10, 8'h40, 2'b00, 9'h000, 2'b10},
    {3'd4, 8'h00, 2'b11, 8'h40, 2'b00, 9'h000, 2'b10},
    {3'd5, 8'h00, 2'b11, 8'hFF, 2'b10, 9'h000, 2'b01},
    {3'd3, 8'h00, 2'b01, 8'hFF, 2'b00, 9'h000, 2'b01},
    {3'd3, 8'h00, 2'b11, 8'hFF, 2'b01, 9'h1FF, 2'b01},
    {3'd4, 8'h00, 2'b11, 8'hFF, 2'b00, 9'h000, 2'b01},
    {3'd6, 8'hC0, 2'b11, 8'hBF, 2'b10, 9'h000, 2'b00},
    {3'd2, 8'h00, 2'b11, 8'hC0, 2'b00, 9'h000, 2'b10},
    {3'd4, 8'h00, 2'b11, 8'hC0, 2'b00, 9'h000, 2'b10},
    {3'd6, 8'h00, 2'b11, 8'h80, 2'b00, 9'h000, 2'b00},
    {3'd1, 8'h00, 2'b11, 8'h00, 2'b00, 9'h000, 2'b00},
    {3'd4, 8'h00, 2'b01, 8'h00, 2'b00, 9'h000, 2'b00},
    {3'd6, 8'h00, 2'b11, 8'h00, 2'b00, 9'h000, 2'b00},
    {3'd4, 8'h00, 2'b11, 8'h00, 2'b00, 9'h000, 2'b00},
    {3'd3, 8'h00, 2'b11, 8'hC0, 2'b01, 9'h180, 2'b10},
    {3'd6, 8'h00, 2'b11, 8'hBF, 2'b00, 9'h000, 2'b00}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd6:    return "R2";
      3'd5:    return "R3";
      3'd3:    return "R6";
      3'd2:    return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] opnd,
                       input logic pre, input logic wr, input logic [7:0] probe);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_operand = opnd;
    pin_pre = pre; pin_wr = wr; chk_addr = probe;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic func_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_addr = 8'h00; #0.1;
    check("R1 protected low", {8'h0, chk_protected}, 9'h0);
    chk_addr = 8'hFF; #0.1;
    check("R1 protected top", {8'h0, chk_protected}, 9'h0);
    check("R1 allow_all", {8'h0, allow_all}, 9'h1);
    check("R1 start_busy", {8'h0, start_busy}, 9'h0);
    check("R1 rd_valid", {8'h0, rd_valid}, 9'h0);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      issue(v[33:31], v[30:23], v[22], v[21], v[20:13]);
      check({tag_of(v[33:31]), " busy"}, {8'h0, start_busy}, {8'h0, v[12]});
      check({tag_of(v[33:31]), " rd_valid"}, {8'h0, rd_valid}, {8'h0, v[11]});
      if (v[11]) check({tag_of(v[33:31]), " rd_data"}, rd_data, v[10:2]);
      check({tag_of(v[33:31]), " protected"}, {8'h0, chk_protected}, {8'h0, v[1]});
      check({tag_of(v[33:31]), " allow_all"}, {8'h0, allow_all}, {8'h0, v[0]});
    end

    // R5: pre low on the write itself, write enable still set
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd6, 8'h00, 1'b0, 1'b1, 8'hC0);
    check("R5 busy", {8'h0, start_busy}, 9'h0);
    check("R5 protected", {8'h0, chk_protected}, 9'h1);

    // R8: functional reset drops write enable, keeps boundary
    func_reset();
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd6, 8'h00, 1'b1, 1'b1, 8'hC0);
    check("R8 busy", {8'h0, start_busy}, 9'h0);
    check("R8 protected", {8'h0, chk_protected}, 9'h1);
    check("R8 allow_all", {8'h0, allow_all}, 9'h0);

    // R7: lock
    issue(3'd1, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd7, 8'h00, 1'b1, 1'b1, 8'hC0);
    check("R7 lock busy", {8'h0, start_busy}, 9'h1);
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'h00);
    issue(3'd6, 8'h00, 1'b1, 1'b1, 8'h00);
    check("R7 write busy", {8'h0, start_busy}, 9'h0);
    check("R7 write protected", {8'h0, chk_protected}, 9'h0);
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd5, 8'h00, 1'b1, 1'b1, 8'hC0);
    check("R7 clear busy", {8'h0, start_busy}, 9'h0);
    check("R7 clear allow_all", {8'h0, allow_all}, 9'h0);
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd7, 8'h00, 1'b1, 1'b1, 8'hC0);
    check("R7 relock busy", {8'h0, start_busy}, 9'h0);
    func_reset();
    issue(3'd1, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd4, 8'h00, 1'b1, 1'b1, 8'hC0);
    issue(3'd6, 8'h00, 1'b1, 1'b1, 8'hC0);
    check("R7 after reset busy", {8'h0, start_busy}, 9'h0);
    issue(3'd3, 8'h00, 1'b1, 1'b1, 8'hC0);
    check("R7 read rd_valid", {8'h0, rd_valid}, 9'h1);
    check("R7 read rd_data", rd_data, 9'h180);

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule